// File: doc/BRIEF.md
# Routed Level Interrupt Aggregator

This block gathers nine level-sensitive interrupt inputs and drives three interrupt request outputs towards a processor. A shared polarity register states, for each input, whether the input counts as asserted when high or when low. Each output line has its own register. That register holds an enable mask and a set of sticky pending flags, one bit of each for every input.

An input is routed to an output by setting its enable bit in that output's register. While an input is asserted at its configured polarity, its pending flag is set on every line. An output line goes high when any of its pending flags has its enable bit set.

Software clears a pending flag by writing one to it. Because every input is level sensitive, a flag that is cleared while its input is still asserted sets again on the next clock. All registers are reached through a simple 32-bit register port with single-cycle strobes. Read data comes back one cycle after the read strobe.

Top module: `irqagg_top`

## Requirements
- R1: The register port uses a 4-bit word address. Word 0 is the polarity register and word 1+n is the register of output line n, for n = 0..2. A read strobe (valid with write enable low) presents the word on the read data port after the next rising clock edge.
- R2: Polarity bit n (bits 8:0 of word 0) set to 1 makes input n asserted when high. Set to 0, it makes input n asserted when low. Bits 31:9 of word 0 read as zero.
- R3: A line register holds the enable mask in bits 8:0 and the pending flags in bits 24:16 (the flag for input n is bit 16+n). All other bits read as zero. A write loads the mask from bits 8:0.
- R4: On every clock edge where input n is asserted at its polarity, pending flag n is set on all three lines, whatever the state of that line's enable bits.
- R5: Writing 1 to bit 16+n of a line register clears that line's flag n at that edge. If input n is still asserted at the same edge, the flag stays set.
- R6: Writing 0 to a pending bit leaves that flag unchanged. A flag holds until it is acknowledged.
- R7: Output n is a register. It is high one edge after its line holds a flag whose enable bit is set, and low one edge after no such flag remains.
- R8: Lines are independent. An acknowledge written to one line does not clear the flags of the other lines.
- R9: A synchronous active-high reset clears the polarity register (every input asserted when low), all masks, all pending flags and all outputs.
- R10: Word addresses 4 to 15 read as zero, and writes to them change no register.
- R11: Writing 0x01FF0000 to a line register clears every pending flag whose input is inactive and disables every input on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl_i | input | 9 | Level interrupt inputs, synchronous to clk |
| bus_vld_i | input | 1 | Register access strobe, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 3 | Interrupt request lines, active high |

## Verification
A pending flag changes at the first edge that samples its input, or that samples the register write that acknowledges it. The matching interrupt output follows one edge later, and read data appears at the edge that samples the read strobe. The driver sets all inputs at a falling edge, so each effect lands at a known rising edge. It then waits whole cycles before checking: one for pending state and two for an output line. A polarity change costs one extra edge, because the new setting is only used after it has been registered. A monitor samples read data just after the rising edge that captured the strobe and pops the expected word that the driver queued with it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // register kinds decoded from the word address
  typedef enum logic [1:0] {
    REG_POL  = 2'd0,
    REG_LINE = 2'd1,
    REG_NONE = 2'd2
  } reg_kind_e;

  // Classify a word address: 0 = polarity, 1..lines = line registers
  function automatic reg_kind_e decode_kind(input int unsigned addr,
                                            input int unsigned lines);
    if (addr == 0)
      return REG_POL;
    else if (addr <= lines)
      return REG_LINE;
    else
      return REG_NONE;
  endfunction

endpackage

// File: rtl/irqagg_polarity.sv
module irqagg_polarity #(
  parameter int unsigned SRC_N = 9,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic [SRC_N-1:0] src_i,
  output logic [SRC_N-1:0] pol_q,
  output logic [SRC_N-1:0] active_o
);

  always_ff @(posedge clk) begin
    if (rst)
      pol_q <= '0;
    else if (wr_en)
      pol_q <= wdata[SRC_N-1:0];
  end

  // an input is asserted when its level equals its polarity bit
  assign active_o = ~(src_i ^ pol_q);

  // R9: reset leaves every input active-low
  a_r9_pol_reset: assert property (@(posedge clk) rst |=> (pol_q == '0));

endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
  parameter int unsigned SRC_N    = 9,
  parameter int unsigned DW       = 32,
  parameter int unsigned PEND_LSB = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic [SRC_N-1:0] active_i,
  output logic [SRC_N-1:0] mask_q,
  output logic [SRC_N-1:0] pend_q,
  output logic             irq_o
);

  logic [SRC_N-1:0] ack_vec;

  assign ack_vec = wr_en ? wdata[PEND_LSB +: SRC_N] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_en)
        mask_q <= wdata[SRC_N-1:0];
      // level capture wins over a same-edge acknowledge
      pend_q <= (pend_q & ~ack_vec) | active_i;
      irq_o  <= |(pend_q & mask_q);
    end
  end

  // R4: an asserted input is pending after the edge
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    (|active_i) |=> ((pend_q & $past(active_i)) == $past(active_i)));

  // R5: acknowledged flags of inactive inputs clear
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ((ack_vec & ~active_i) != '0) |=> ((pend_q & $past(ack_vec & ~active_i)) == '0));

  // R6: without a write, no flag is lost
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R7: output follows enabled pending one edge later
  a_r7_irq_on: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & mask_q) != '0) |=> irq_o);
  a_r7_irq_off: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & mask_q) == '0) |=> !irq_o);

endmodule

// File: rtl/irqagg_regbus.sv
module irqagg_regbus
  import irqagg_pkg::*;
#(
  parameter int unsigned SRC_N    = 9,
  parameter int unsigned LINE_N   = 3,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 4,
  parameter int unsigned PEND_LSB = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          vld_i,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  input  logic [SRC_N-1:0]              pol_i,
  input  logic [LINE_N-1:0][SRC_N-1:0]  mask_i,
  input  logic [LINE_N-1:0][SRC_N-1:0]  pend_i,
  output logic                          pol_wr_o,
  output logic [LINE_N-1:0]             line_wr_o,
  output logic [DW-1:0]                 wdata_o
);

  reg_kind_e   kind;
  logic [DW-1:0] rd_word;

  assign kind    = decode_kind(int'(addr_i), LINE_N);
  assign wdata_o = wdata_i;
  assign pol_wr_o = vld_i && we_i && (kind == REG_POL);

  for (genvar l = 0; l < LINE_N; l++) begin : g_wdec
    assign line_wr_o[l] = vld_i && we_i && (addr_i == AW'(l + 1));
  end

  always_comb begin
    rd_word = '0;
    if (kind == REG_POL) begin
      rd_word[SRC_N-1:0] = pol_i;
    end else if (kind == REG_LINE) begin
      for (int l = 0; l < LINE_N; l++) begin
        if (addr_i == AW'(l + 1)) begin
          rd_word[SRC_N-1:0]          = mask_i[l];
          rd_word[PEND_LSB +: SRC_N]  = pend_i[l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (vld_i && !we_i)
      rdata_o <= rd_word;
  end

  // R10: unused words read back as zero
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !we_i && (int'(addr_i) > LINE_N)) |=> (rdata_o == '0));

  // R1: at most one register is written per strobe
  a_r1_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pol_wr_o, line_wr_o}));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
  parameter int unsigned SRC_N    = 9,
  parameter int unsigned LINE_N   = 3,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 4,
  parameter int unsigned PEND_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  src_lvl_i,
  input  logic              bus_vld_i,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [LINE_N-1:0] irq_o
);

  logic [SRC_N-1:0]             pol_q;
  logic [SRC_N-1:0]             active;
  logic                         pol_wr;
  logic [LINE_N-1:0]            line_wr;
  logic [DW-1:0]                wdata;
  logic [LINE_N-1:0][SRC_N-1:0] mask_all;
  logic [LINE_N-1:0][SRC_N-1:0] pend_all;

  irqagg_regbus #(
    .SRC_N(SRC_N), .LINE_N(LINE_N), .DW(DW), .AW(AW), .PEND_LSB(PEND_LSB)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .vld_i     (bus_vld_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .pol_i     (pol_q),
    .mask_i    (mask_all),
    .pend_i    (pend_all),
    .pol_wr_o  (pol_wr),
    .line_wr_o (line_wr),
    .wdata_o   (wdata)
  );

  irqagg_polarity #(.SRC_N(SRC_N), .DW(DW)) u_pol (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (pol_wr),
    .wdata    (wdata),
    .src_i    (src_lvl_i),
    .pol_q    (pol_q),
    .active_o (active)
  );

  for (genvar l = 0; l < LINE_N; l++) begin : g_line
    irqagg_line #(.SRC_N(SRC_N), .DW(DW), .PEND_LSB(PEND_LSB)) u_line (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (line_wr[l]),
      .wdata    (wdata),
      .active_i (active),
      .mask_q   (mask_all[l]),
      .pend_q   (pend_all[l]),
      .irq_o    (irq_o[l])
    );
  end

  // R9: reset quiets every output
  a_r9_irq_reset: assert property (@(posedge clk) rst |=> (irq_o == '0));

endmodule

// File: tb/irqagg_tb_top.sv
`timescale 1ns/100ps
module irqagg_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  src = 9'h1FF;
  logic        vld = 1'b0;
  logic        we  = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expq[$];
  string       tagq[$];

  always #2.5 clk = ~clk;

  irqagg_top dut_i (
    .clk         (clk),
    .rst         (rst),
    .src_lvl_i   (src),
    .bus_vld_i   (vld),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    vld = 1'b0; we = 1'b0;
  endtask

  // driver: issues a read and queues the expected word
  task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    vld = 1'b1; we = 1'b0; addr = a;
    expq.push_back(exp);
    tagq.push_back(tag);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: read data is due just after the edge that took the strobe
  always @(posedge clk) begin
    logic fire;
    fire = vld && !we && !rst;
    #1;
    if (fire) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 read with no expectation actual=%h expected=none", rdata);
      end else begin
        check(tagq.pop_front(), rdata, expq.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R9 reset state
    check("R9 irq after reset", {29'd0, irq}, 32'h0);
    bus_rd(4'd0, 32'h0, "R9 polarity reset");
    bus_rd(4'd1, 32'h0, "R9 line0 reset");
    bus_rd(4'd3, 32'h0, "R9 line2 reset");

    // inputs low with active-low polarity, then switch to active high
    @(negedge clk); src = 9'h000;
    bus_wr(4'd0, 32'h0000_01FF);
    bus_rd(4'd1, 32'h01FF_0000, "R2 active-low capture");
    bus_rd(4'd0, 32'h0000_01FF, "R2 polarity readback");
    // R11 init writes
    bus_wr(4'd1, 32'h01FF_0000);
    bus_wr(4'd2, 32'h01FF_0000);
    bus_wr(4'd3, 32'h01FF_0000);
    bus_rd(4'd2, 32'h0, "R11 init clears line1");
    bus_rd(4'd3, 32'h0, "R11 init clears line2");

    // routing: line0 <- 3, line1 <- 3,5, line2 none
    bus_wr(4'd1, 32'h0000_0008);
    bus_wr(4'd2, 32'h0000_0028);
    @(negedge clk); src = 9'h008;
    @(negedge clk);
    check("R7 no irq before latency", {29'd0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq routed lines 0,1", {29'd0, irq}, 32'h3);
    bus_rd(4'd3, 32'h0008_0000, "R4 capture without enable");
    bus_rd(4'd2, 32'h0008_0028, "R3 line1 layout");

    // R5: acknowledge while still asserted
    bus_wr(4'd1, 32'h0008_0008);
    bus_rd(4'd1, 32'h0008_0008, "R5 level resets flag");
    check("R5 irq0 held", {31'd0, irq[0]}, 32'h1);

    // drop input, acknowledge line0 only
    @(negedge clk); src = 9'h000;
    bus_wr(4'd1, 32'h0008_0008);
    @(negedge clk);
    check("R8 only line0 drops", {29'd0, irq}, 32'h2);
    bus_rd(4'd1, 32'h0000_0008, "R5 ack clears");
    bus_rd(4'd2, 32'h0008_0028, "R8 line1 keeps flag");

    // R6: writing zeros to pending bits
    bus_wr(4'd2, 32'h0000_0028);
    bus_rd(4'd2, 32'h0008_0028, "R6 zero write no effect");

    // R2: input 5 active low, unused polarity bits read zero
    bus_wr(4'd0, 32'hFFFF_FFDF);
    cyc(2);
    bus_rd(4'd0, 32'h0000_01DF, "R2 upper bits zero");
    bus_rd(4'd2, 32'h0028_0028, "R2 active-low input 5");
    bus_rd(4'd1, 32'h0020_0008, "R4 line0 holds masked 5");
    check("R7 masked flag keeps irq0 low", {29'd0, irq}, 32'h2);

    // highest input on line2, acknowledge all with mask 8
    @(negedge clk); src = 9'h100;
    bus_wr(4'd3, 32'h01FF_0100);
    @(negedge clk);
    check("R7 input 8 on line2", {29'd0, irq}, 32'h6);
    bus_rd(4'd3, 32'h0120_0100, "R11 ack-all keeps live flags");

    // R10 unused words
    bus_wr(4'd5, 32'hFFFF_FFFF);
    bus_rd(4'd5, 32'h0, "R10 word5 reads zero");
    bus_rd(4'd15, 32'h0, "R10 word15 reads zero");
    bus_rd(4'd0, 32'h0000_01DF, "R10 write ignored polarity");
    bus_rd(4'd3, 32'h0120_0100, "R10 write ignored line2");

    // R9 reset mid-run
    @(negedge clk); src = 9'h1FF; rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check("R9 irq cleared", {29'd0, irq}, 32'h0);
    bus_rd(4'd0, 32'h0, "R9 polarity cleared");
    bus_rd(4'd2, 32'h0, "R9 line1 cleared");
    cyc(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule